// File: doc/BRIEF.md
# Buffered Input Capture Channel

This block is one channel of a capture timer. On each qualified capture event it stores the value of a free-running 16-bit timer in a capture register. A holding register sits behind the capture register, so software can collect two timestamps before it must service the channel. The mode input sets how values move from the capture register to the holding register.

In latch mode, a value moves to the holding register only when the latch request input is pulsed. That request can come from a modulus counter reaching zero, from a write of zero to that counter, or from a software command. In queue mode, every new capture pushes the older capture value into the holding register. A no-overwrite control stops events from writing a register that still holds unread data. In queue mode, reading the holding register also takes a snapshot of a paired pulse-accumulator count.

Top module: `bufcap_channel`

## Requirements
- R1: After a synchronous active-low reset, `cap_q`, `hold_q` and `pacc_hold` are 0, and `cap_vld` and `hold_vld` are 0.
- R2: With `no_ovw`=0, a `cap_evt` pulse loads the current `timer_val` into `cap_q` on the next clock in either mode, and sets `cap_vld`.
- R3: In latch mode (`latch_mode`=1), a `latch_req` pulse copies `cap_q` into `hold_q`, sets `hold_vld` and clears `cap_vld`. This happens whether `cap_vld` was set or not, unless R7 blocks it. Without `latch_req`, `hold_q` does not change in latch mode.
- R4: In latch mode with `no_ovw`=0, a new capture overwrites an unread `cap_q`, and a new latch request overwrites an unread `hold_q`.
- R5: In queue mode (`latch_mode`=0) with `no_ovw`=0, a capture while `cap_vld`=1 moves the old `cap_q` into `hold_q`, sets `hold_vld`, and loads the new timer value into `cap_q`.
- R6: With `no_ovw`=1, a capture is dropped while `cap_vld`=1, unless a transfer out of the capture register happens in the same cycle. A captured value is therefore kept until it is read (`rd_cap`) or transferred.
- R7: With `no_ovw`=1 and `hold_vld`=1, `hold_q` is not written. In latch mode the latch request is ignored and `cap_vld` stays set. In queue mode a capture while both registers are valid is dropped.
- R8: In queue mode, `rd_hold` copies `pacc_cnt` into `pacc_hold` on the next clock. In latch mode, `rd_hold` leaves `pacc_hold` unchanged. In queue mode, `latch_req` has no effect on any output.
- R9: When a capture and a latch request arrive in the same cycle in latch mode, the old `cap_q` goes to `hold_q` and the new timer value goes to `cap_q`. Both valid flags end up set.
- R10: `rd_cap` clears `cap_vld` and `rd_hold` clears `hold_vld`. When a read and a write to the same register share a cycle, the flag stays set and the register takes the new value.
- R11: In queue mode, a capture while `cap_vld`=0 loads `cap_q` only; `hold_q` and `hold_vld` are unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| timer_val | input | 16 | Free-running timer value |
| cap_evt | input | 1 | Qualified capture event, one cycle per edge |
| latch_mode | input | 1 | 1 = latch mode, 0 = queue mode |
| no_ovw | input | 1 | 1 = protect unread registers from event writes |
| latch_req | input | 1 | Latch request (used in latch mode only) |
| rd_cap | input | 1 | Read strobe for the capture register |
| rd_hold | input | 1 | Read strobe for the holding register |
| pacc_cnt | input | 16 | Paired pulse-accumulator count |
| cap_q | output | 16 | Capture register |
| hold_q | output | 16 | Holding register |
| cap_vld | output | 1 | Capture register holds unread data |
| hold_vld | output | 1 | Holding register holds unread data |
| pacc_hold | output | 16 | Pulse-accumulator snapshot |

## Verification
The assertions check these properties on every cycle:
- an unprotected capture always loads the timer value;
- a queue push carries the old capture value into the holding register;
- a full, protected holding register never changes;
- the holding register is stable in latch mode when no request arrives;
- a same-cycle read and write leave the flag set;
- the pulse-accumulator snapshot follows the mode rule.

Only the bench scenarios can show the event orderings against a reference model. These are dropped captures under protection and their release after a read, chained queue pushes, the latch-first ordering of a shared cycle, and mode changes while data sits in the registers.

// File: rtl/bufcap_pkg.sv
// Package: shared types for the buffered capture channel.
// Assumes a single clock domain; widths are set by the modules' parameters.
package bufcap_pkg;

    typedef enum logic {
        MODE_QUEUE = 1'b0,
        MODE_LATCH = 1'b1
    } buf_mode_e;

    // Per-cycle control strobes from the sequencer to the storage
    typedef struct packed {
        logic push;    // copy capture register into holding register
        logic wr_cap;  // load timer value into capture register
        logic snap;    // take a pulse-accumulator snapshot
    } buf_ctl_t;

endpackage

// File: rtl/bufcap_ctrl.sv
// Module: bufcap_ctrl
// Decides, each cycle, whether to transfer, capture and snapshot, and keeps
// the two valid flags. Assumes single-cycle strobes sampled on clk.
// Transfers are resolved before captures in the same cycle.
module bufcap_ctrl
    import bufcap_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  buf_mode_e mode,
    input  logic      no_ovw,
    input  logic      cap_evt,
    input  logic      latch_req,
    input  logic      rd_cap,
    input  logic      rd_hold,
    output buf_ctl_t  ctl,
    output logic      cap_vld,
    output logic      hold_vld
);

    logic hold_open;
    logic cap_free;

    // Purpose: derive the transfer, capture and snapshot strobes
    always_comb begin
        hold_open = !no_ovw || !hold_vld;
        if (mode == MODE_LATCH) begin
            ctl.push = latch_req && hold_open;
        end else begin
            ctl.push = cap_evt && cap_vld && hold_open;
        end
        cap_free   = !cap_vld || ctl.push;
        ctl.wr_cap = cap_evt && (!no_ovw || cap_free);
        ctl.snap   = (mode == MODE_QUEUE) && rd_hold;
    end

    // Purpose: track capture register occupancy
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cap_vld <= 1'b0;
        end else if (ctl.wr_cap) begin
            cap_vld <= 1'b1;
        end else if (ctl.push || rd_cap) begin
            cap_vld <= 1'b0;
        end
    end

    // Purpose: track holding register occupancy
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hold_vld <= 1'b0;
        end else if (ctl.push) begin
            hold_vld <= 1'b1;
        end else if (rd_hold) begin
            hold_vld <= 1'b0;
        end
    end

    // R10
    rd_wr_cap_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_cap && cap_evt && !no_ovw) |=> cap_vld);

    // R10
    rd_clear_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_hold && !latch_req && !cap_evt) |=> !hold_vld);

    // R6
    cap_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (no_ovw && cap_vld && !rd_cap && !ctl.push) |=> cap_vld);

endmodule

// File: rtl/bufcap_regs.sv
// Module: bufcap_regs
// Data storage: capture register and holding register.
// Assumes push and wr_cap come from bufcap_ctrl in the same cycle;
// push takes the pre-capture value of the capture register.
module bufcap_regs #(
    parameter int unsigned TW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [TW-1:0] timer_val,
    input  logic          push,
    input  logic          wr_cap,
    output logic [TW-1:0] cap_q,
    output logic [TW-1:0] hold_q
);

    localparam logic [TW-1:0] ZERO = '0;

    // Purpose: capture register load
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cap_q <= ZERO;
        end else if (wr_cap) begin
            cap_q <= timer_val;
        end
    end

    // Purpose: holding register load from the capture register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hold_q <= ZERO;
        end else if (push) begin
            hold_q <= cap_q;
        end
    end

    // R2
    cap_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_cap |=> cap_q == $past(timer_val));

    // R3
    hold_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !push |=> $stable(hold_q));

endmodule

// File: rtl/bufcap_pacc.sv
// Module: bufcap_pacc
// Pulse-accumulator snapshot register, loaded when snap is high.
// Assumes snap is already qualified by mode in bufcap_ctrl.
module bufcap_pacc #(
    parameter int unsigned TW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          snap,
    input  logic [TW-1:0] pacc_cnt,
    output logic [TW-1:0] pacc_hold
);

    // Purpose: snapshot the accumulator count
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pacc_hold <= '0;
        end else if (snap) begin
            pacc_hold <= pacc_cnt;
        end
    end

    // R8
    pacc_snap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        snap |=> pacc_hold == $past(pacc_cnt));

endmodule

// File: rtl/bufcap_channel.sv
// Module: bufcap_channel (top)
// A capture channel with two registers: latch or queue transfer policy,
// optional no-overwrite protection, and a pulse-accumulator snapshot.
// Assumes cap_evt is already edge-qualified and the strobes last one cycle.
module bufcap_channel
    import bufcap_pkg::*;
#(
    parameter int unsigned TW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [TW-1:0] timer_val,
    input  logic          cap_evt,
    input  logic          latch_mode,
    input  logic          no_ovw,
    input  logic          latch_req,
    input  logic          rd_cap,
    input  logic          rd_hold,
    input  logic [TW-1:0] pacc_cnt,
    output logic [TW-1:0] cap_q,
    output logic [TW-1:0] hold_q,
    output logic          cap_vld,
    output logic          hold_vld,
    output logic [TW-1:0] pacc_hold
);

    buf_mode_e mode;
    buf_ctl_t  ctl;

    assign mode = buf_mode_e'(latch_mode);

    bufcap_ctrl u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .mode      (mode),
        .no_ovw    (no_ovw),
        .cap_evt   (cap_evt),
        .latch_req (latch_req),
        .rd_cap    (rd_cap),
        .rd_hold   (rd_hold),
        .ctl       (ctl),
        .cap_vld   (cap_vld),
        .hold_vld  (hold_vld)
    );

    bufcap_regs #(.TW(TW)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .timer_val (timer_val),
        .push      (ctl.push),
        .wr_cap    (ctl.wr_cap),
        .cap_q     (cap_q),
        .hold_q    (hold_q)
    );

    bufcap_pacc #(.TW(TW)) u_pacc (
        .clk       (clk),
        .rst_n     (rst_n),
        .snap      (ctl.snap),
        .pacc_cnt  (pacc_cnt),
        .pacc_hold (pacc_hold)
    );

    // R7
    hold_protect_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (no_ovw && hold_vld) |=> $stable(hold_q));

    // R5
    queue_push_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!latch_mode && cap_evt && !no_ovw && cap_vld)
        |=> (hold_q == $past(cap_q)) && hold_vld);

    // R9
    latch_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (latch_mode && cap_evt && latch_req && !no_ovw)
        |=> (hold_q == $past(cap_q)) && (cap_q == $past(timer_val)));

    // R3
    latch_hold_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (latch_mode && !latch_req) |=> $stable(hold_q));

    // R8
    latch_pacc_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        latch_mode |=> $stable(pacc_hold));

endmodule

// File: tb/sim_bufcap_channel.sv
// Bench for bufcap_channel: a behavioural reference model is updated on
// every rising edge and compared with all outputs after every clock.
module sim_bufcap_channel;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] timer_val = 16'h0100;
    logic        cap_evt = 1'b0;
    logic        latch_mode = 1'b1;
    logic        no_ovw = 1'b0;
    logic        latch_req = 1'b0;
    logic        rd_cap = 1'b0;
    logic        rd_hold = 1'b0;
    logic [15:0] pacc_cnt = 16'h5000;
    logic [15:0] cap_q, hold_q, pacc_hold;
    logic        cap_vld, hold_vld;

    int errors = 0;
    int checks = 0;
    string cur_req = "R1";

    int m_cap = 0, m_hold = 0, m_pacc = 0;
    bit m_cv = 0, m_hv = 0;

    always #4 clk = ~clk;

    bufcap_channel u0 (
        .clk(clk), .rst_n(rst_n), .timer_val(timer_val), .cap_evt(cap_evt),
        .latch_mode(latch_mode), .no_ovw(no_ovw), .latch_req(latch_req),
        .rd_cap(rd_cap), .rd_hold(rd_hold), .pacc_cnt(pacc_cnt),
        .cap_q(cap_q), .hold_q(hold_q), .cap_vld(cap_vld),
        .hold_vld(hold_vld), .pacc_hold(pacc_hold)
    );

    // Reference model, written from the requirements
    always @(posedge clk) begin
        int old_cap;
        bit moved;
        if (!rst_n) begin
            m_cap = 0; m_hold = 0; m_pacc = 0; m_cv = 0; m_hv = 0;
        end else begin
            old_cap = m_cap;
            moved = 0;
            if (rd_cap) m_cv = 0;
            if (rd_hold) m_hv = 0;
            if (latch_mode) begin
                if (latch_req && !(no_ovw && m_hv_pre())) begin
                    m_hold = old_cap; m_hv = 1; m_cv = 0; moved = 1;
                end
                if (cap_evt && (!no_ovw || !m_cv_pre() || moved)) begin
                    m_cap = int'(timer_val); m_cv = 1;
                end
            end else begin
                if (cap_evt) begin
                    if (!m_cv_pre()) begin
                        m_cap = int'(timer_val); m_cv = 1;
                    end else if (!no_ovw || !m_hv_pre()) begin
                        m_hold = old_cap; m_hv = 1;
                        m_cap = int'(timer_val); m_cv = 1;
                    end
                end
                if (rd_hold) m_pacc = int'(pacc_cnt);
            end
        end
    end

    // Flag values before this edge (the DUT outputs still show them)
    function automatic bit m_cv_pre();
        return cap_vld;
    endfunction
    function automatic bit m_hv_pre();
        return hold_vld;
    endfunction

    task automatic chk(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic compare_all();
        chk(cur_req, "cap_q", int'(cap_q), m_cap);
        chk(cur_req, "hold_q", int'(hold_q), m_hold);
        chk(cur_req, "cap_vld", int'(cap_vld), int'(m_cv));
        chk(cur_req, "hold_vld", int'(hold_vld), int'(m_hv));
        chk(cur_req, "pacc_hold", int'(pacc_hold), m_pacc);
    endtask

    // One clock: drive strobes, clock, then compare away from the edge
    task automatic cyc(input bit e, input bit l, input bit rc, input bit rh);
        cap_evt = e; latch_req = l; rd_cap = rc; rd_hold = rh;
        @(posedge clk);
        #2;
        cap_evt = 0; latch_req = 0; rd_cap = 0; rd_hold = 0;
        timer_val = timer_val + 16'd13;
        pacc_cnt = pacc_cnt + 16'd3;
        compare_all();
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin : stim
        logic [15:0] t0, c0;
        repeat (3) @(posedge clk);
        #2;
        // R1: reset state
        cur_req = "R1";
        compare_all();
        chk("R1", "cap_q zero", int'(cap_q), 0);
        chk("R1", "flags zero", int'({cap_vld, hold_vld}), 0);
        rst_n = 1'b1;

        // R2: latch mode captures, no protection
        cur_req = "R2"; latch_mode = 1; no_ovw = 0;
        t0 = timer_val;
        cyc(1, 0, 0, 0);
        chk("R2", "cap_q direct", int'(cap_q), int'(t0));
        cyc(0, 0, 0, 0);
        // R4: overwrite capture, then latch twice
        cur_req = "R4";
        cyc(1, 0, 0, 0);
        cyc(0, 1, 0, 0);
        cyc(1, 0, 0, 0);
        cyc(0, 1, 0, 0);
        // R3: latch with empty capture, then reads
        cur_req = "R3";
        cyc(0, 0, 0, 1);
        cyc(0, 1, 0, 0);
        cyc(0, 0, 0, 0);
        cyc(0, 0, 1, 1);
        // R9: capture and latch together
        cur_req = "R9";
        cyc(1, 0, 0, 0);
        c0 = cap_q; t0 = timer_val;
        cyc(1, 1, 0, 0);
        chk("R9", "hold gets old capture", int'(hold_q), int'(c0));
        chk("R9", "cap gets new timer", int'(cap_q), int'(t0));
        // R10: read and write to the capture register together
        cur_req = "R10";
        cyc(1, 0, 1, 0);
        chk("R10", "cap_vld kept", int'(cap_vld), 1);
        cyc(0, 0, 1, 1);
        chk("R10", "flags cleared", int'({cap_vld, hold_vld}), 0);
        // R6: protection on the capture register in latch mode
        cur_req = "R6"; no_ovw = 1;
        cyc(1, 0, 0, 0);
        c0 = cap_q;
        cyc(1, 0, 0, 0);
        chk("R6", "capture kept", int'(cap_q), int'(c0));
        cyc(0, 0, 1, 0);
        cyc(1, 0, 0, 0);
        // R7: holding register full and protected in latch mode
        cur_req = "R7";
        cyc(0, 1, 0, 0);
        cyc(1, 0, 0, 0);
        c0 = hold_q;
        cyc(0, 1, 0, 0);
        chk("R7", "hold kept", int'(hold_q), int'(c0));
        chk("R7", "cap_vld kept", int'(cap_vld), 1);
        cyc(1, 1, 0, 0);
        cyc(0, 0, 1, 1);
        // R5: queue mode pushes
        cur_req = "R5"; latch_mode = 0; no_ovw = 0;
        cyc(1, 0, 0, 0);
        cyc(1, 0, 0, 0);
        c0 = cap_q;
        cyc(1, 0, 0, 0);
        chk("R5", "push old capture", int'(hold_q), int'(c0));
        cyc(1, 0, 0, 0);
        // R8: snapshot rules and ignored latch request
        cur_req = "R8";
        t0 = pacc_cnt;
        cyc(0, 0, 0, 1);
        chk("R8", "pacc snapshot", int'(pacc_hold), int'(t0));
        cyc(0, 1, 0, 0);
        cyc(0, 1, 0, 0);
        latch_mode = 1;
        c0 = pacc_hold;
        cyc(0, 0, 0, 1);
        chk("R8", "latch mode no snapshot", int'(pacc_hold), int'(c0));
        latch_mode = 0;
        // R11: queue capture into an empty capture register
        cur_req = "R11";
        cyc(0, 0, 1, 0);
        cyc(0, 1, 0, 0);
        c0 = hold_q;
        cyc(1, 0, 0, 0);
        chk("R11", "hold unchanged", int'(hold_q), int'(c0));
        // R7: queue mode with both registers full and protected
        cur_req = "R7"; no_ovw = 1;
        cyc(1, 0, 0, 0);
        cyc(1, 0, 0, 0);
        c0 = cap_q;
        cyc(1, 0, 0, 0);
        chk("R7", "queue capture dropped", int'(cap_q), int'(c0));
        cyc(1, 0, 0, 1);
        cyc(1, 0, 0, 0);
        // R6: queue protection released by reading the capture register
        cur_req = "R6";
        cyc(0, 0, 1, 1);
        cyc(1, 0, 0, 0);
        cyc(1, 0, 1, 0);
        cyc(0, 0, 0, 0);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule